// File: doc/BRIEF.md
# Bitmap Line Serializer with Row Doubling

This block turns a small monochrome bitmap into a 1-bit pixel stream for a video line. At the start of every line it gets a pulse and the frame-wide line number. It folds that number into an index within the field. It then decides whether the line falls inside a fixed vertical image window. For a line inside the window, it reads a set number of bytes from an internal glyph ROM. It shifts each byte out most significant bit first, one bit for every pixel-clock enable.

Each bitmap row is drawn on two successive lines, so the image appears twice its stored height. The row pointer goes back to zero on any line outside the window, which means every field starts from the top of the image. The pointer wraps back to zero when it runs past the end of the stored image. A pixel-active flag goes with the pixel bit, and both return to black after the last bit of every line. Sync timing and analog output levels are handled elsewhere.

Top module: `bitmap_line_serializer`

## Requirements
- R1: While `rst_n` is low, `pix_out` and `pix_act` are 0.
- R2: A line is drawn only when the folded field index is strictly greater than `WIN_START` and strictly less than `WIN_START + 2*WIN_ROWS`. On a line outside that range, `pix_act` stays 0.
- R3: A frame line number greater than `FIELD_LINES` is folded by subtracting `FIELD_LINES`. Any other value is used unchanged.
- R4: A drawn line emits exactly `IMG_W_BYTES*8` bits. Each byte goes out MSB first, and the bytes come from consecutive addresses. One bit is emitted per clock on which `pix_en` is high, starting with the first `pix_en` clock that comes at least two clocks after the clock that sampled `line_start`. `pix_act` is 1 for each emitted bit.
- R5: Drawn lines k = 0, 1, 2, ... since the last out-of-window line use row k/2 (integer division). The row start address therefore advances by `IMG_W_BYTES` only every second drawn line.
- R6: A read address that reaches `IMG_H*IMG_W_BYTES` wraps to 0. This applies both to the row start address and to the address used inside a line.
- R7: On the first `pix_en` clock after the last bit of a line, `pix_out` and `pix_act` go to 0. The outputs change only on clocks with `pix_en` high.
- R8: A `line_start` on a line outside the window resets the row pointer, so the next drawn line uses row 0.
- R9: The ROM byte at address a is (a*29 + 83) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| line_start | input | 1 | One-cycle pulse at the start of the active part of a line |
| line_idx | input | LINE_W | Frame line number for the line that is starting |
| pix_en | input | 1 | Pixel clock enable; one pixel period per high cycle |
| pix_out | output | 1 | Pixel bit (1 = lit) |
| pix_act | output | 1 | High while a bitmap bit is being shown |

## Verification
The clock that samples `line_start` latches the row address. The ROM read takes one more clock. The first bit can therefore appear at the earliest on the output register two clocks after the pulse, and each later bit appears on the clock of its own `pix_en`. The bench model copies this timing. It advances a queue of expected bits only on `pix_en` clocks whose run phase has started, and it compares both outputs after every rising edge, at the falling edge. Line sequences cover both fields and the window borders. They are run with a continuous enable, enables every second and every third clock, and an irregular enable, so the gap between fetch and use varies.

// File: rtl/bls_pkg.sv
package bls_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_RUN  = 2'd2
  } ser_state_e;

  // R9: glyph content, computed rather than tabulated
  function automatic logic [7:0] glyph_byte(input int unsigned a);
    return 8'((a * 29 + 83) % 256);
  endfunction

endpackage

// File: rtl/bls_line_window.sv
module bls_line_window #(
  parameter int LINE_W      = 10,
  parameter int WIN_START   = 118,
  parameter int WIN_ROWS    = 32,
  parameter int FIELD_LINES = 312
) (
  input  logic [LINE_W-1:0] line_idx,
  output logic              in_win
);
  localparam int WIN_END = WIN_START + 2 * WIN_ROWS;

  logic [LINE_W-1:0] folded;

  // R3: fold frame line into field line
  always_comb begin
    if (int'(line_idx) > FIELD_LINES) folded = line_idx - LINE_W'(FIELD_LINES);
    else                              folded = line_idx;
  end

  // R2: strict window bounds
  assign in_win = (int'(folded) > WIN_START) && (int'(folded) < WIN_END);
endmodule

// File: rtl/bls_row_base.sv
module bls_row_base #(
  parameter int IMG_W_BYTES = 8,
  parameter int IMG_H       = 32,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              in_win,
  output logic [ADDR_W-1:0] base_q
);
  localparam int DEPTH = IMG_H * IMG_W_BYTES;

  logic              phase_q, phase_n;
  logic [ADDR_W-1:0] base_n;
  logic [ADDR_W:0]   sum;

  assign sum = {1'b0, base_q} + (ADDR_W+1)'(IMG_W_BYTES);

  always_comb begin
    base_n  = base_q;
    phase_n = phase_q;
    if (line_start) begin
      if (!in_win) begin
        // R8: out-of-window line restarts the image
        base_n  = '0;
        phase_n = 1'b0;
      end else begin
        // R5: advance only after the second showing of a row
        phase_n = ~phase_q;
        if (phase_q) begin
          // R6: wrap past the image end
          if (int'(sum) >= DEPTH) base_n = '0;
          else                    base_n = sum[ADDR_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      base_q  <= base_n;
      phase_q <= phase_n;
    end
  end
endmodule

// File: rtl/bls_rom.sv
module bls_rom #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        data_q
);
  import bls_pkg::*;

  localparam int SLOTS = 1 << ADDR_W;

  logic [7:0] table_w [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < DEPTH) begin : g_used
      assign table_w[i] = glyph_byte(i);
    end else begin : g_unused
      assign table_w[i] = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= 8'h00;
    else        data_q <= table_w[addr];
  end
endmodule

// File: rtl/bls_shifter.sv
module bls_shifter #(
  parameter int IMG_W_BYTES = 8,
  parameter int DEPTH       = 256,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              in_win,
  input  logic              pix_en,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [7:0]        rom_data,
  output logic [ADDR_W-1:0] rd_addr_q,
  output logic              pix_out_q,
  output logic              pix_act_q
);
  import bls_pkg::*;

  localparam int BC_W = (IMG_W_BYTES > 1) ? $clog2(IMG_W_BYTES) : 1;

  ser_state_e        state_q, state_n;
  logic [ADDR_W-1:0] rd_addr_n, addr_inc;
  logic [7:0]        sh_q, sh_n, cur;
  logic [2:0]        bit_q, bit_n;
  logic [BC_W-1:0]   byte_q, byte_n;
  logic              pix_out_n, pix_act_n;

  // R6: address wrap inside a line
  assign addr_inc = (int'(rd_addr_q) >= DEPTH - 1) ? '0 : rd_addr_q + 1'b1;
  assign cur      = (bit_q == 3'd0) ? rom_data : sh_q;

  always_comb begin
    state_n   = state_q;
    rd_addr_n = rd_addr_q;
    sh_n      = sh_q;
    bit_n     = bit_q;
    byte_n    = byte_q;
    pix_out_n = pix_out_q;
    pix_act_n = pix_act_q;

    if (pix_en) begin
      if (state_q == ST_RUN) begin
        // R4: MSB first, one bit per enable
        pix_out_n = cur[7];
        pix_act_n = 1'b1;
        sh_n      = {cur[6:0], 1'b0};
        bit_n     = bit_q + 3'd1;
        if (bit_q == 3'd0) rd_addr_n = addr_inc;
        if (bit_q == 3'd7) begin
          if (int'(byte_q) == IMG_W_BYTES - 1) state_n = ST_IDLE;
          else                                 byte_n  = byte_q + 1'b1;
        end
      end else begin
        // R7: black outside the drawn bits
        pix_out_n = 1'b0;
        pix_act_n = 1'b0;
      end
    end

    if (line_start) begin
      if (in_win) begin
        state_n   = ST_PREP;
        rd_addr_n = base_addr;
      end else begin
        state_n   = ST_IDLE;
      end
    end else if (state_q == ST_PREP) begin
      state_n = ST_RUN;
      bit_n   = 3'd0;
      byte_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rd_addr_q <= '0;
      sh_q      <= 8'h00;
      bit_q     <= 3'd0;
      byte_q    <= '0;
      pix_out_q <= 1'b0;
      pix_act_q <= 1'b0;
    end else begin
      state_q   <= state_n;
      rd_addr_q <= rd_addr_n;
      sh_q      <= sh_n;
      bit_q     <= bit_n;
      byte_q    <= byte_n;
      pix_out_q <= pix_out_n;
      pix_act_q <= pix_act_n;
    end
  end
endmodule

// File: rtl/bitmap_line_serializer.sv
module bitmap_line_serializer #(
  parameter int LINE_W      = 10,
  parameter int IMG_W_BYTES = 8,
  parameter int IMG_H       = 32,
  parameter int WIN_ROWS    = 32,
  parameter int WIN_START   = 118,
  parameter int FIELD_LINES = 312
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_idx,
  input  logic              pix_en,
  output logic              pix_out,
  output logic              pix_act
);
  localparam int DEPTH  = IMG_H * IMG_W_BYTES;
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              in_win;
  logic [ADDR_W-1:0] base_addr, rd_addr;
  logic [7:0]        rom_data;

  bls_line_window #(
    .LINE_W(LINE_W), .WIN_START(WIN_START),
    .WIN_ROWS(WIN_ROWS), .FIELD_LINES(FIELD_LINES)
  ) u_window (
    .line_idx(line_idx),
    .in_win  (in_win)
  );

  bls_row_base #(
    .IMG_W_BYTES(IMG_W_BYTES), .IMG_H(IMG_H), .ADDR_W(ADDR_W)
  ) u_row (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_start(line_start),
    .in_win    (in_win),
    .base_q    (base_addr)
  );

  bls_rom #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rom (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (rd_addr),
    .data_q(rom_data)
  );

  bls_shifter #(
    .IMG_W_BYTES(IMG_W_BYTES), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_start(line_start),
    .in_win    (in_win),
    .pix_en    (pix_en),
    .base_addr (base_addr),
    .rom_data  (rom_data),
    .rd_addr_q (rd_addr),
    .pix_out_q (pix_out),
    .pix_act_q (pix_act)
  );
endmodule

// File: rtl/bls_checker.sv
module bls_checker #(
  parameter int LINE_W      = 10,
  parameter int WIN_ROWS    = 32,
  parameter int WIN_START   = 118,
  parameter int FIELD_LINES = 312
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_start,
  input logic [LINE_W-1:0] line_idx,
  input logic              pix_en,
  input logic              pix_out,
  input logic              pix_act
);
  int   fl;
  logic win_now, start_q, last_in_q;

  assign fl      = (int'(line_idx) > FIELD_LINES) ? int'(line_idx) - FIELD_LINES : int'(line_idx);
  assign win_now = (fl > WIN_START) && (fl < WIN_START + 2 * WIN_ROWS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= 1'b0;
      last_in_q <= 1'b0;
    end else begin
      start_q <= line_start;
      if (line_start) last_in_q <= win_now;
    end
  end

  // R7
  black_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_act |-> !pix_out);

  // R7
  hold_without_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(pix_out) && $stable(pix_act)));

  // R4
  first_bit_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && pix_en) |=> !pix_act);

  // R2
  window_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_act && !start_q) |-> last_in_q);
endmodule

bind bitmap_line_serializer bls_checker #(
  .LINE_W(LINE_W), .WIN_ROWS(WIN_ROWS),
  .WIN_START(WIN_START), .FIELD_LINES(FIELD_LINES)
) u_bls_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_start(line_start),
  .line_idx  (line_idx),
  .pix_en    (pix_en),
  .pix_out   (pix_out),
  .pix_act   (pix_act)
);

// File: tb/test_bitmap_line_serializer.sv
module test_bitmap_line_serializer;
  localparam int LW = 10;
  localparam int WB = 2;
  localparam int H  = 4;
  localparam int WR = 6;
  localparam int WS = 118;
  localparam int FL = 312;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          line_start = 1'b0;
  logic [LW-1:0] line_idx = '0;
  logic          pix_en = 1'b0;
  logic          pix_out, pix_act;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int pe_mode = 1;
  logic [15:0] lfsr = 16'hACE1;
  logic        done = 1'b0;

  // expected-value model state
  int   mode = 0;           // 0 idle, 1 waiting one clock, 2 running
  int   drawn = 0;          // drawn lines since last out-of-window line
  bit   exp_q[$];
  logic exp_out = 1'b0;
  logic exp_act = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  bitmap_line_serializer #(
    .LINE_W(LW), .IMG_W_BYTES(WB), .IMG_H(H),
    .WIN_ROWS(WR), .WIN_START(WS), .FIELD_LINES(FL)
  ) i_bitmap_line_serializer (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .line_idx(line_idx), .pix_en(pix_en),
    .pix_out(pix_out), .pix_act(pix_act)
  );

  function automatic int rom_ref(int a);   // R9
    return (a * 29 + 83) % 256;
  endfunction

  // reference model, advanced at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 0; drawn = 0; exp_q.delete();
      exp_out = 1'b0; exp_act = 1'b0;
    end else begin
      if (pix_en) begin
        if (mode == 2) begin            // R4: one bit per enable
          exp_out = exp_q.pop_front();
          exp_act = 1'b1;
          if (exp_q.size() == 0) mode = 0;
        end else begin                  // R7: black after last bit
          exp_out = 1'b0;
          exp_act = 1'b0;
        end
      end
      if (line_start) begin
        int f;
        f = (int'(line_idx) > FL) ? int'(line_idx) - FL : int'(line_idx);  // R3
        exp_q.delete();
        if (f > WS && f < WS + 2 * WR) begin                                // R2
          int b;
          b = ((drawn / 2) % H) * WB;                                       // R5, R6
          drawn++;
          for (int j = 0; j < WB; j++) begin
            int v;
            v = rom_ref((b + j) % (H * WB));
            for (int k = 7; k >= 0; k--) exp_q.push_back(v[k] != 0);
          end
          mode = 1;
        end else begin                                                      // R8
          drawn = 0;
          mode = 0;
        end
      end else if (mode == 1) begin
        mode = 2;
      end
    end
  end

  // compare after every rising edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      n_cmp++;
      if (pix_act !== exp_act || pix_out !== exp_out) begin
        n_bad++;
        if (pix_act !== exp_act)
          $display("FAIL %s cycle %0d: pix_act=%b expected %b",
                   exp_act ? "R4" : "R2", cyc, pix_act, exp_act);
        else
          $display("FAIL %s cycle %0d: pix_out=%b expected %b",
                   exp_act ? "R9" : "R7", cyc, pix_out, exp_out);
      end
    end
  end

  // pixel enable patterns, driven away from the rising edge
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (pe_mode)
      1: pix_en <= 1'b1;
      2: pix_en <= (cyc % 2) == 0;
      3: pix_en <= (cyc % 3) == 0;
      default: pix_en <= lfsr[0] ^ lfsr[3];
    endcase
  end

  task automatic run_line(int ln);
    @(negedge clk);
    line_idx   = LW'(ln);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    repeat (90) @(negedge clk);
  endtask

  task automatic run_field(int off);
    run_line(off + 5);                           // R8 reset of row pointer
    for (int l = WS; l <= WS + 2 * WR + 1; l++) run_line(off + l);   // R2 borders, R5, R6
    run_line(off + 200);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (pix_out !== 1'b0 || pix_act !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: out=%b act=%b expected 0 0", pix_out, pix_act);
    end
    rst_n = 1'b1;
    for (int m = 1; m <= 4; m++) begin
      pe_mode = m;
      run_field(0);        // first field
      run_field(FL);       // second field, folded (R3)
    end
    run_line(FL);          // 312 is not folded, outside window
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule